// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-programmed master for the Clause 45 MDIO management bus. It is used to reach the registers of external PHYs. A host sees four 32-bit registers, chosen by a 2-bit select: a status/configuration register, a control register, an address register and a data register. Each frame is launched by a different register access:

- A write to the address register sends an address frame carrying a register number.
- A write to the data register sends a write frame carrying a 16-bit value.
- A write to the control register with its read bit set sends a read frame. The 16 bits that the PHY returns are stored in the data register.

The block makes the management clock MDC from the system clock with a programmable divider. It drives MDIO through an output value and an output enable, and it samples the returned line on a separate input. Busy is reported in two places. The status register shows busy while an address frame or a read frame runs. The data register shows busy while a write frame or a read frame runs. A missing PHY is reported as a read error.

Every frame is 64 bits, sent most significant bit first, in this order:

- 32 ones (preamble).
- Start code 00.
- A 2-bit opcode.
- The 5-bit port address.
- The 5-bit device address.
- Two turnaround bits.
- 16 payload bits.

Top module: `mdio45_master`

## Requirements
- R1: After reset the status register reads 0x0000_6400 (divider 100, busy 0, read error 0). The control, address and data registers read 0. MDC is low and the MDIO output enable is low.
- R2: The register select codes are 0 status, 1 control, 2 address and 3 data. Status holds busy in bit 0, read error in bit 1 and the divider in bits 15:8. Control holds the read trigger in bit 15, the port address in bits 9:5 and the device address in bits 4:0. Address holds bits 15:0. Data holds busy in bit 31 and the value in bits 15:0. All other bits read 0, and the read trigger bit reads 0.
- R3: Writing the address register sends an address frame with opcode 00, turnaround 10 and the written value as payload. MDIO is driven for all 64 bits. Status busy is 1 and data busy is 0 while the frame runs.
- R4: Writing the data register sends a write frame with opcode 01, turnaround 10 and the written value as payload. MDIO is driven for all 64 bits. Data busy is 1 and status busy is 0 while the frame runs.
- R5: Writing the control register with bit 15 set sends a read frame with opcode 11, using the port and device addresses from that same write. MDIO is driven for the first 46 bits and released for the two turnaround bits and the 16 data bits. Both busy bits are 1 while the frame runs. The 16 bits sampled by the master are stored in data bits 15:0.
- R6: If the second turnaround bit of a read frame is sampled high, the read error bit is set. It is cleared when the next frame starts.
- R7: MDC stays high for divider+1 system clocks and stays low for divider+1 system clocks. MDC is low while idle. MDIO changes only on a falling edge of MDC, and read data is sampled on the rising edge.
- R8: While a frame is in progress, every register write is ignored. No register changes and no further frame starts.
- R9: A control write with bit 15 clear only stores the two address fields and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data for the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO input as seen on the pin |

## Verification
The hardest case to reach is the read frame. In a read frame the master releases the line and must sample a PHY that answers in step with MDC edges the master itself generates. The bench models a PHY that counts falling MDC edges from the start of each read and puts each turnaround and data bit on the line after the matching edge. The same model is then switched off, so the line floats high, to produce the read-error path. Writes issued in the middle of a frame exercise the ignore rule, and the register contents and the enable count are checked once the bus is idle again.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_IDX     = 46;  // first turnaround bit index
  localparam int DATA_IDX   = 48;  // first payload bit index

  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } op_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input op_e op, input logic [4:0] prt, input logic [4:0] dev,
      input logic [15:0] payload);
    return {32'hFFFF_FFFF, 2'b00, op, prt, dev, 2'b10, payload};
  endfunction

endpackage

// File: rtl/mdio45_clkgen.sv
module mdio45_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             wrap;

  assign wrap = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_evt = wrap && !mdc_q;
  assign fall_evt = wrap && mdc_q;

endmodule

// File: rtl/mdio45_seq.sv
module mdio45_seq
  import mdio45_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  op_e                   start_op,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  rise_evt,
  input  logic                  fall_evt,
  input  logic                  mdio_i,
  output logic                  active,
  output op_e                   cur_op,
  output logic [5:0]            bit_idx,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic                  ta_err,
  output logic [15:0]           rx_data
);

  logic                  active_q, active_d;
  op_e                   op_q, op_d;
  logic [5:0]            idx_q, idx_d, idx_nxt;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  oe_q, oe_d;
  logic [15:0]           rx_q, rx_d;
  logic                  is_read;

  assign is_read = (op_q == OP_READ);
  assign idx_nxt = idx_q + 6'd1;

  always_comb begin
    active_d = active_q;
    op_d     = op_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    rx_d     = rx_q;
    done     = 1'b0;
    ta_err   = 1'b0;
    if (!active_q) begin
      if (start) begin
        active_d = 1'b1;
        op_d     = start_op;
        idx_d    = '0;
        sh_d     = frame;
        oe_d     = 1'b1;
        rx_d     = '0;
      end
    end else begin
      if (rise_evt && is_read) begin
        if (idx_q == 6'(TA_IDX + 1)) ta_err = mdio_i;
        if (idx_q >= 6'(DATA_IDX))   rx_d   = {rx_q[14:0], mdio_i};
      end
      if (fall_evt) begin
        if (idx_q == 6'(FRAME_BITS - 1)) begin
          active_d = 1'b0;
          oe_d     = 1'b0;
          sh_d     = '1;
          done     = 1'b1;
        end else begin
          idx_d = idx_nxt;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
          oe_d  = !(is_read && (idx_nxt >= 6'(TA_IDX)));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      op_q     <= OP_ADDR;
      idx_q    <= '0;
      sh_q     <= '1;
      oe_q     <= 1'b0;
      rx_q     <= '0;
    end else begin
      active_q <= active_d;
      op_q     <= op_d;
      idx_q    <= idx_d;
      sh_q     <= sh_d;
      oe_q     <= oe_d;
      rx_q     <= rx_d;
    end
  end

  assign active  = active_q;
  assign cur_op  = op_q;
  assign bit_idx = idx_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = oe_q;
  assign rx_data = rx_q;

endmodule

// File: rtl/mdio45_regs.sv
module mdio45_regs
  import mdio45_pkg::*;
#(
  parameter int          DIV_W   = 8,
  parameter logic [7:0]  DIV_RST = 8'd100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [31:0]           wr_data,
  input  logic [1:0]            rd_sel,
  output logic [31:0]           rd_data,
  input  logic                  active,
  input  op_e                   cur_op,
  input  logic                  done,
  input  logic                  ta_err,
  input  logic [15:0]           rx_data,
  output logic                  start,
  output op_e                   start_op,
  output logic [FRAME_BITS-1:0] frame,
  output logic [DIV_W-1:0]      div
);

  logic [DIV_W-1:0] div_q, div_d;
  logic             err_q, err_d;
  logic [4:0]       prt_q, prt_d, dev_q, dev_d;
  logic [15:0]      addr_q, addr_d, data_q, data_d;
  logic             accept, stat_busy, data_busy;
  logic [4:0]       f_prt, f_dev;
  logic [15:0]      f_pay;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[31:16], wr_data[14:10]};
  assign accept = wr_en && !active;

  always_comb begin
    start    = 1'b0;
    start_op = OP_ADDR;
    f_prt    = prt_q;
    f_dev    = dev_q;
    f_pay    = wr_data[15:0];
    if (accept) begin
      unique case (wr_sel)
        SEL_ADDR: begin start = 1'b1; start_op = OP_ADDR;  end
        SEL_DATA: begin start = 1'b1; start_op = OP_WRITE; end
        SEL_CTRL: if (wr_data[15]) begin
          start    = 1'b1;
          start_op = OP_READ;
          f_prt    = wr_data[9:5];
          f_dev    = wr_data[4:0];
          f_pay    = 16'hFFFF;
        end
        default: ;
      endcase
    end
  end

  assign frame = build_frame(start_op, f_prt, f_dev, f_pay);

  always_comb begin
    div_d  = div_q;
    err_d  = err_q;
    prt_d  = prt_q;
    dev_d  = dev_q;
    addr_d = addr_q;
    data_d = data_q;
    if (accept) begin
      unique case (wr_sel)
        SEL_STAT: div_d  = wr_data[8 +: DIV_W];
        SEL_CTRL: begin prt_d = wr_data[9:5]; dev_d = wr_data[4:0]; end
        SEL_ADDR: addr_d = wr_data[15:0];
        SEL_DATA: data_d = wr_data[15:0];
        default: ;
      endcase
    end
    if (start)                        err_d  = 1'b0;
    if (ta_err)                       err_d  = 1'b1;
    if (done && cur_op == OP_READ)    data_d = rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_RST[DIV_W-1:0];
      err_q  <= 1'b0;
      prt_q  <= '0;
      dev_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      div_q  <= div_d;
      err_q  <= err_d;
      prt_q  <= prt_d;
      dev_q  <= dev_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign stat_busy = active && (cur_op != OP_WRITE);
  assign data_busy = active && (cur_op != OP_ADDR);
  assign div       = div_q;

  always_comb begin
    rd_data = '0;
    unique case (rd_sel)
      SEL_STAT: begin
        rd_data[8 +: DIV_W] = div_q;
        rd_data[1]          = err_q;
        rd_data[0]          = stat_busy;
      end
      SEL_CTRL: rd_data[9:0]  = {prt_q, dev_q};
      SEL_ADDR: rd_data[15:0] = addr_q;
      SEL_DATA: rd_data       = {data_busy, 15'd0, data_q};
      default: ;
    endcase
  end

endmodule

// File: rtl/mdio45_master.sv
module mdio45_master
  import mdio45_pkg::*;
#(
  parameter int         DIV_W   = 8,
  parameter logic [7:0] DIV_RST = 8'd100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic [1:0]            rst_sync_q;
  logic                  rst_q_n;
  logic                  active, done, ta_err, start, rise_evt, fall_evt;
  op_e                   cur_op, start_op;
  logic [5:0]            bit_idx;
  logic [15:0]           rx_data;
  logic [FRAME_BITS-1:0] frame;
  logic [DIV_W-1:0]      clk_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  mdio45_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .active(active), .cur_op(cur_op), .done(done), .ta_err(ta_err),
    .rx_data(rx_data), .start(start), .start_op(start_op),
    .frame(frame), .div(clk_div)
  );

  mdio45_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_q_n), .run(active), .div(clk_div),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio45_seq u_seq (
    .clk(clk), .rst_n(rst_q_n), .start(start), .start_op(start_op),
    .frame(frame), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .mdio_i(mdio_i), .active(active), .cur_op(cur_op), .bit_idx(bit_idx),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .ta_err(ta_err),
    .rx_data(rx_data)
  );

endmodule

// File: rtl/mdio45_master_chk.sv
module mdio45_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             active,
  input logic [1:0]       op,
  input logic [5:0]       bit_idx,
  input logic [DIV_W-1:0] div
);

  logic [DIV_W:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_cnt <= '0;
    else if (!mdc) hi_cnt <= '0;
    else          hi_cnt <= hi_cnt + 1'b1;
  end

  AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!mdio_oe && !mdc)); // R7
  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc)); // R7
  AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_cnt == {1'b0, div} + 1'b1)); // R7
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && op == 2'b11 && bit_idx >= 6'd46) |-> !mdio_oe); // R5
  AST_READ_HEAD_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && op == 2'b11 && bit_idx < 6'd46) |-> mdio_oe); // R5
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && op != 2'b11) |-> mdio_oe); // R3

endmodule

bind mdio45_master mdio45_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .active(active), .op(cur_op), .bit_idx(bit_idx),
  .div(clk_div)
);

// File: tb/mdio45_master_tb.sv
module mdio45_master_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mdio45_master u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: counts falling MDC edges since frame start
  bit          phy_en;
  logic [15:0] phy_resp;
  int          fcnt;
  always @(negedge mdc) fcnt = fcnt + 1;
  always_comb begin
    if (phy_en && fcnt == 47)                  mdio_i = 1'b0;
    else if (phy_en && fcnt >= 48 && fcnt <= 63) mdio_i = phy_resp[63 - fcnt];
    else                                       mdio_i = 1'b1;
  end

  // Line capture on rising MDC
  logic [63:0] cap;
  int          oe_cnt;
  always @(posedge mdc) begin
    cap    = {cap[62:0], mdio_oe ? mdio_o : 1'b1};
    oe_cnt = oe_cnt + (mdio_oe ? 1 : 0);
  end

  // MDC phase measurement in system clocks
  int cyc = 0, t_rise = 0, t_fall = 0, last_hi = 0, last_lo = 0;
  always @(negedge clk) cyc = cyc + 1;
  always @(posedge mdc) begin last_lo = cyc - t_fall; t_rise = cyc; end
  always @(negedge mdc) begin last_hi = cyc - t_rise; t_fall = cyc; end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [31:0] d);
    rd_sel = sel;
    #0.5;
    d = rd_data;
  endtask

  task automatic arm();
    fcnt = 0; cap = '0; oe_cnt = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s, d;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      reg_rd(2'd0, s);
      reg_rd(2'd3, d);
      if (!s[0] && !d[31]) break;
    end
    @(negedge clk);
  endtask

  function automatic logic [63:0] exp_frame(input logic [1:0] op,
      input logic [4:0] p, input logic [4:0] dv, input logic [15:0] pl);
    return {32'hFFFF_FFFF, 2'b00, op, p, dv, 2'b10, pl};
  endfunction

  // kind[44:43] prt[42:38] dev[37:33] payload[32:17] phy[16] resp[15:0]
  localparam int NV = 6;
  localparam logic [44:0] VEC [NV] = '{
    {2'b00, 5'd1,  5'd1,  16'h0000, 1'b0, 16'h0000},
    {2'b01, 5'd31, 5'd30, 16'hA5C3, 1'b0, 16'h0000},
    {2'b11, 5'd5,  5'd3,  16'h0000, 1'b1, 16'h1234},
    {2'b00, 5'd0,  5'd31, 16'hFFFF, 1'b0, 16'h0000},
    {2'b11, 5'd17, 5'd7,  16'h0000, 1'b1, 16'h8001},
    {2'b01, 5'd10, 5'd21, 16'h0000, 1'b0, 16'h0000}
  };

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2;
    wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    phy_en = 0; phy_resp = 0; fcnt = 0; cap = 0; oe_cnt = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_rd(2'd0, r); check(r == 32'h6400, "R1 status", r, 32'h6400);
    reg_rd(2'd1, r); check(r == 0, "R1 control", r, 0);
    reg_rd(2'd2, r); check(r == 0, "R1 address", r, 0);
    reg_rd(2'd3, r); check(r == 0, "R1 data", r, 0);
    check(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 0);

    // R2 field positions, R9 control write without trigger
    reg_wr(2'd1, 32'hFFFF_7FFF);
    reg_rd(2'd1, r); check(r == 32'h3FF, "R2 control fields", r, 32'h3FF);
    reg_rd(2'd0, r); check(r[0] == 0, "R9 no frame started", r, 0);
    repeat (20) @(negedge clk);
    check(!mdc && !mdio_oe, "R9 bus idle", {mdc, mdio_oe}, 0);
    reg_wr(2'd0, 32'hFFFF_0103);
    reg_rd(2'd0, r); check(r == 32'h0100, "R2 status fields", r, 32'h0100);

    // table of frames
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;  logic [4:0] p, dv;
      logic [15:0] pl, rs; logic [63:0] ef; logic [31:0] st, dt;
      k = VEC[i][44:43]; p = VEC[i][42:38]; dv = VEC[i][37:33];
      pl = VEC[i][32:17]; phy_en = VEC[i][16]; rs = VEC[i][15:0];
      phy_resp = rs;
      reg_wr(2'd1, {22'd0, p, dv});
      arm();
      if (k == 2'b00)      reg_wr(2'd2, {16'hDEAD, pl});
      else if (k == 2'b01) reg_wr(2'd3, {16'hBEEF, pl});
      else                 reg_wr(2'd1, {16'd0, 1'b1, 5'd0, p, dv});
      reg_rd(2'd0, st); reg_rd(2'd3, dt);
      if (k == 2'b00)
        check(st[0] && !dt[31], "R3 busy flags", {st[0], dt[31]}, 2'b10);
      else if (k == 2'b01)
        check(!st[0] && dt[31], "R4 busy flags", {st[0], dt[31]}, 2'b01);
      else
        check(st[0] && dt[31], "R5 busy flags", {st[0], dt[31]}, 2'b11);
      wait_idle();
      ef = exp_frame(k, p, dv, (k == 2'b11) ? 16'hFFFF : pl);
      if (k == 2'b11) begin
        check(cap[63:18] == ef[63:18], "R5 read header", cap, ef);
        check(oe_cnt == 46, "R5 release", oe_cnt, 46);
        reg_rd(2'd3, r); check(r == {16'd0, rs}, "R5 captured data", r, rs);
        reg_rd(2'd0, r); check(r[1] == 0, "R6 no error", r[1], 0);
      end else begin
        check(cap == ef, (k == 2'b00) ? "R3 frame" : "R4 frame", cap, ef);
        check(oe_cnt == 64, "R3 R4 drive", oe_cnt, 64);
        if (k == 2'b01) begin
          reg_rd(2'd3, r); check(r == {16'd0, pl}, "R4 data reg", r, pl);
        end else begin
          reg_rd(2'd2, r); check(r == {16'd0, pl}, "R3 addr reg", r, pl);
        end
      end
    end

    // R7 phase lengths with divider 3
    reg_wr(2'd0, 32'h0300);
    arm();
    reg_wr(2'd3, 32'h0000_1357);
    wait_idle();
    check(last_hi == 4, "R7 high phase", last_hi, 4);
    check(last_lo == 4, "R7 low phase", last_lo, 4);
    check(!mdc, "R7 idle low", mdc, 0);
    reg_wr(2'd0, 32'h0100);

    // R6 read with no PHY: error set, all ones
    phy_en = 0;
    arm();
    reg_wr(2'd1, 32'h0000_8000 | {22'd0, 5'd9, 5'd2});
    wait_idle();
    reg_rd(2'd0, r); check(r[1] == 1, "R6 error set", r[1], 1);
    reg_rd(2'd3, r); check(r == 32'h0000_FFFF, "R6 floating data", r, 32'hFFFF);
    arm();
    reg_wr(2'd2, 32'h0000_0042);
    reg_rd(2'd0, r); check(r[1:0] == 2'b01, "R6 error cleared on start", r[1:0], 2'b01);
    wait_idle();

    // R8 writes during a frame ignored
    arm();
    reg_wr(2'd2, 32'h0000_0777);
    reg_wr(2'd3, 32'h0000_BEEF);
    reg_wr(2'd2, 32'h0000_1111);
    reg_wr(2'd1, 32'h0000_83FF);
    reg_wr(2'd0, 32'h0000_0500);
    wait_idle();
    reg_rd(2'd2, r);  check(r == 32'h777, "R8 address kept", r, 32'h777);
    reg_rd(2'd3, r);  check(r == 32'hFFFF, "R8 data kept", r, 32'hFFFF);
    reg_rd(2'd1, r);  check(r == {22'd0, 5'd9, 5'd2}, "R8 control kept", r, {5'd9, 5'd2});
    reg_rd(2'd0, r2); check(r2 == 32'h0100, "R8 divider kept", r2, 32'h0100);
    check(oe_cnt == 64, "R8 single frame", oe_cnt, 64);
    repeat (20) @(negedge clk);
    check(!mdc && !mdio_oe, "R8 no follow-up frame", {mdc, mdio_oe}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule